// File: doc/BRIEF.md
# Dual-Mode Parallel Display Bus Writer

This block turns single-byte write requests from a host into write cycles on an 8-bit parallel bus that feeds a display controller. A mode input picks between two handshake styles. The first is an enable-style bus with an active-high enable pin and a read/write select pin. The second is a strobe-style bus with separate active-low read and write pins. Each request carries a byte and a flag that says whether the byte is display data or a command. The flag is driven onto the data/command line for the whole cycle.

Every cycle runs through four timed phases. SETUP selects the chip and presents the qualifier and data. STROBE asserts the write strobe. HOLD releases the strobe while the chip stays selected. RECOVER deselects the chip. The length of each phase in system clocks is worked out at elaboration from nanosecond minimums and the clock period. The results are rounded up, and every phase lasts at least one cycle. With the defaults (10 ns clock), the phases take 1, 6, 1 and 22 cycles, for a 30-cycle bus cycle.

The controller has five states: IDLE, SETUP, STROBE, HOLD and RECOVER. Its transitions are:
- IDLE→SETUP on an accepted request.
- SETUP→STROBE, STROBE→HOLD and HOLD→RECOVER when the phase timer expires.
- RECOVER→IDLE when the phase timer expires.

Top module: `pbus_writer`

## Requirements
- R1: While and after reset, and before any request, the pins sit at these levels: `bus_cs_n`=1, `bus_oe`=0, `bus_rw_wrn`=1, `bus_e_rdn`=0 (enable-style idle), `in_ready`=1, `bus_d`=0, `bus_dc`=0.
- R2: `in_ready` is high only in IDLE. A request is taken on the clock edge where `in_valid` and `in_ready` are both high. While a cycle is in progress, changes on `in_valid`, `in_data`, `in_is_data` and `mode_80` have no effect on that cycle.
- R3: `mode_80`=0 selects the enable-style bus and `mode_80`=1 selects the strobe-style bus. The mode is captured when the request is accepted.
- R4: Enable-style cycle: `bus_rw_wrn` (read/write select) is 0 whenever the chip is selected, otherwise 1. `bus_e_rdn` (enable) is 1 only during STROBE.
- R5: Strobe-style cycle: `bus_rw_wrn` (write strobe, active low) is 0 only during STROBE. `bus_e_rdn` (read strobe) stays at 1.
- R6: The first clock after acceptance starts SETUP. Chip select (`bus_cs_n`=0) holds through SETUP, STROBE and HOLD, lasting SETUP_CYC, ACTIVE_CYC and HOLD_CYC cycles respectively. RECOVER then keeps `bus_cs_n`=1 for RECOVER_CYC cycles before IDLE.
- R7: `bus_dc` equals `in_is_data` of the accepted request (1 = display data, 0 = command). `bus_d` equals its byte. Both stay stable from the start of SETUP until the next request is accepted.
- R8: `bus_oe` is 1 exactly while chip select is asserted.
- R9: Consecutive chip-select falling edges are at least SETUP+ACTIVE+HOLD+RECOVER cycles apart, which is no less than the minimum bus cycle. With `in_valid` held, they are exactly one cycle more apart than that.
- R10: In IDLE the strobe pins sit at the inactive levels of the last captured mode: `bus_rw_wrn`=1, and `bus_e_rdn`=0 for enable-style or 1 for strobe-style.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_80 | input | 1 | 0 = enable-style bus, 1 = strobe-style bus |
| in_valid | input | 1 | Host request valid |
| in_ready | output | 1 | Writer idle and able to accept |
| in_data | input | DATA_W | Byte to write |
| in_is_data | input | 1 | 1 = display data, 0 = command |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_dc | output | 1 | Data/command line |
| bus_rw_wrn | output | 1 | Read/write select (enable-style) or write strobe (strobe-style) |
| bus_e_rdn | output | 1 | Enable (enable-style) or read strobe (strobe-style) |
| bus_d | output | DATA_W | Data bus value |
| bus_oe | output | 1 | Data bus output enable |

## Verification
The assertions assume that `rst_n` is released synchronously to `clk`. They also assume that the request inputs change only away from the active clock edge. They place no limit on how the host toggles `in_valid` or `mode_80` during a cycle, because R2 states that such changes are ignored. The stimulus drives every input on the falling edge. It issues requests back to back. In about a quarter of the cycles it deliberately raises `in_valid` with an inverted byte, an inverted flag and a flipped mode while the writer is busy, and drops it before the writer returns to IDLE.

// File: rtl/pbw_pkg.sv
`timescale 1ns/1ps
package pbw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_STROBE,
        ST_HOLD,
        ST_RECOVER
    } pbw_state_e;

    // Round a nanosecond minimum up to whole clock cycles.
    function automatic int ns_to_cyc(input int ns, input int clk_ns);
        return (ns + clk_ns - 1) / clk_ns;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/pbw_phase_timer.sv
`timescale 1ns/1ps
module pbw_phase_timer #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/pbw_pin_mapper.sv
`timescale 1ns/1ps
module pbw_pin_mapper (
    input  logic mode_80,
    input  logic selected,
    input  logic strobe,
    output logic cs_n,
    output logic rw_wrn,
    output logic e_rdn
);

    always_comb begin
        cs_n = ~selected;
        if (mode_80) begin
            // strobe-style: active-low write pin, read pin parked high
            rw_wrn = ~strobe;
            e_rdn  = 1'b1;
        end else begin
            // enable-style: select pin low for write while selected, enable high
            rw_wrn = ~selected;
            e_rdn  = strobe;
        end
    end

endmodule

// File: rtl/pbus_writer.sv
`timescale 1ns/1ps
module pbus_writer
    import pbw_pkg::*;
#(
    parameter int DATA_W         = 8,
    parameter int CLK_NS         = 10,
    parameter int ADDR_SETUP_NS  = 10,
    parameter int STROBE_LOW_NS  = 60,
    parameter int STROBE_HIGH_NS = 60,
    parameter int DATA_SETUP_NS  = 40,
    parameter int DATA_HOLD_NS   = 7,
    parameter int BUS_CYCLE_NS   = 300
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_80,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_is_data,
    output logic              bus_cs_n,
    output logic              bus_dc,
    output logic              bus_rw_wrn,
    output logic              bus_e_rdn,
    output logic [DATA_W-1:0] bus_d,
    output logic              bus_oe
);

    localparam int SETUP_CYC   = imax(1, ns_to_cyc(ADDR_SETUP_NS, CLK_NS));
    localparam int ACTIVE_CYC  = imax(1, imax(ns_to_cyc(STROBE_LOW_NS, CLK_NS),
                                              ns_to_cyc(DATA_SETUP_NS, CLK_NS)));
    localparam int HOLD_CYC    = imax(1, ns_to_cyc(DATA_HOLD_NS, CLK_NS));
    localparam int RECOVER_CYC = imax(1, imax(
        ns_to_cyc(BUS_CYCLE_NS, CLK_NS) - (SETUP_CYC + ACTIVE_CYC + HOLD_CYC),
        ns_to_cyc(STROBE_HIGH_NS, CLK_NS) - (SETUP_CYC + HOLD_CYC)));
    localparam int TOTAL_CYC   = SETUP_CYC + ACTIVE_CYC + HOLD_CYC + RECOVER_CYC;
    localparam int MAX_CYC     = imax(imax(SETUP_CYC, ACTIVE_CYC), imax(HOLD_CYC, RECOVER_CYC));
    localparam int CNT_W       = $clog2(MAX_CYC + 1);

    localparam logic [CNT_W-1:0] SETUP_LD   = CNT_W'(SETUP_CYC - 1);
    localparam logic [CNT_W-1:0] ACTIVE_LD  = CNT_W'(ACTIVE_CYC - 1);
    localparam logic [CNT_W-1:0] HOLD_LD    = CNT_W'(HOLD_CYC - 1);
    localparam logic [CNT_W-1:0] RECOVER_LD = CNT_W'(RECOVER_CYC - 1);

    pbw_state_e        state_q, state_d;
    logic              tmr_load;
    logic [CNT_W-1:0]  tmr_val;
    logic              tmr_done;
    logic              accept;
    logic              selected;
    logic              strobe;
    logic [DATA_W-1:0] byte_q;
    logic              dc_q;
    logic              mode_q;

    assign accept = in_valid && in_ready;

    pbw_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_done)
    );

    // next-state and phase-length selection
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (in_valid) begin
                    state_d  = ST_SETUP;
                    tmr_load = 1'b1;
                    tmr_val  = SETUP_LD;
                end
            end
            ST_SETUP: begin
                if (tmr_done) begin
                    state_d  = ST_STROBE;
                    tmr_load = 1'b1;
                    tmr_val  = ACTIVE_LD;
                end
            end
            ST_STROBE: begin
                if (tmr_done) begin
                    state_d  = ST_HOLD;
                    tmr_load = 1'b1;
                    tmr_val  = HOLD_LD;
                end
            end
            ST_HOLD: begin
                if (tmr_done) begin
                    state_d  = ST_RECOVER;
                    tmr_load = 1'b1;
                    tmr_val  = RECOVER_LD;
                end
            end
            ST_RECOVER: begin
                if (tmr_done) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // request capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            byte_q <= '0;
            dc_q   <= 1'b0;
            mode_q <= 1'b0;
        end else if (accept) begin
            byte_q <= in_data;
            dc_q   <= in_is_data;
            mode_q <= mode_80;
        end
    end

    // output decode
    always_comb begin
        in_ready = (state_q == ST_IDLE);
        selected = (state_q == ST_SETUP) || (state_q == ST_STROBE) || (state_q == ST_HOLD);
        strobe   = (state_q == ST_STROBE);
        bus_oe   = selected;
        bus_d    = byte_q;
        bus_dc   = dc_q;
    end

    pbw_pin_mapper u_pins (
        .mode_80  (mode_q),
        .selected (selected),
        .strobe   (strobe),
        .cs_n     (bus_cs_n),
        .rw_wrn   (bus_rw_wrn),
        .e_rdn    (bus_e_rdn)
    );

    // ---------------- assertions ----------------
    logic        str_pin;
    logic [31:0] run_q;
    logic [31:0] since_acc_q;

    assign str_pin = mode_q ? ~bus_rw_wrn : bus_e_rdn;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q       <= '0;
            since_acc_q <= '1;
        end else begin
            run_q <= str_pin ? run_q + 32'd1 : 32'd0;
            if (accept) begin
                since_acc_q <= 32'd0;
            end else if (since_acc_q != '1) begin
                since_acc_q <= since_acc_q + 32'd1;
            end
        end
    end

    a_r2_ready_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> (bus_cs_n && !bus_oe && !str_pin));

    a_r6_accept_starts_setup: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (!bus_cs_n && !str_pin));

    a_r6_strobe_width: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(str_pin) |-> (run_q == 32'(ACTIVE_CYC) && !bus_cs_n));

    a_r4_select_low_in_write: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_q && bus_e_rdn) |-> (!bus_cs_n && !bus_rw_wrn));

    a_r5_read_parked: assert property (@(posedge clk) disable iff (!rst_n)
        mode_q |-> bus_e_rdn);

    a_r7_bus_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_cs_n && $past(!bus_cs_n)) |-> ($stable(bus_d) && $stable(bus_dc)));

    a_r8_oe_with_cs: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |-> !bus_cs_n);

    a_r9_cycle_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> (since_acc_q >= 32'(TOTAL_CYC)));

endmodule

// File: tb/tb_pbus_writer.sv
`timescale 1ns/1ps
module tb_pbus_writer;

    localparam int CLK_PERIOD = 10;

    // phase lengths derived independently from the timing minimums
    function automatic int cdiv(input int a, input int b);
        return (a + b - 1) / b;
    endfunction
    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    localparam int SET   = mx(1, cdiv(10, CLK_PERIOD));
    localparam int ACT   = mx(1, mx(cdiv(60, CLK_PERIOD), cdiv(40, CLK_PERIOD)));
    localparam int HLD   = mx(1, cdiv(7, CLK_PERIOD));
    localparam int REC   = mx(1, mx(cdiv(300, CLK_PERIOD) - (SET + ACT + HLD),
                                    cdiv(60, CLK_PERIOD) - (SET + HLD)));
    localparam int TOTAL = SET + ACT + HLD + REC;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_80 = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [7:0] in_data = 8'h00;
    logic       in_is_data = 1'b0;
    logic       bus_cs_n, bus_dc, bus_rw_wrn, bus_e_rdn, bus_oe;
    logic [7:0] bus_d;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pbus_writer dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_80    (mode_80),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .in_data    (in_data),
        .in_is_data (in_is_data),
        .bus_cs_n   (bus_cs_n),
        .bus_dc     (bus_dc),
        .bus_rw_wrn (bus_rw_wrn),
        .bus_e_rdn  (bus_e_rdn),
        .bus_d      (bus_d),
        .bus_oe     (bus_oe)
    );

    // {ready, cs_n, dc, rw_wrn, e_rdn, oe, data}
    function automatic logic [13:0] expect_pins(input int idx, input bit m80,
                                                input logic [7:0] b, input bit dcf);
        bit sel = (idx < SET + ACT + HLD);
        bit stb = (idx >= SET) && (idx < SET + ACT);
        bit rdy = (idx >= TOTAL);
        bit rw  = m80 ? !stb : !sel;
        bit e   = m80 ? 1'b1 : stb;
        return {rdy, !sel, dcf, rw, e, sel, b};
    endfunction

    function automatic logic [13:0] pins_now();
        return {in_ready, bus_cs_n, bus_dc, bus_rw_wrn, bus_e_rdn, bus_oe, bus_d};
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // chip-select falling-edge spacing monitor (R9)
    int cyc = 0;
    int last_fall = -1;
    int min_gap = 1 << 30;
    bit prev_cs_n = 1'b1;
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (prev_cs_n && !bus_cs_n) begin
                if (last_fall >= 0 && (cyc - last_fall) < min_gap) min_gap = cyc - last_fall;
                last_fall = cyc;
            end
            prev_cs_n = bus_cs_n;
        end
    end

    // One full write cycle; entered and left at a falling edge with the writer idle.
    // The trace compare covers R3 (mode capture), R6 (phase order and lengths),
    // R7 (qualifier and data), R8 (output enable) and R10 (idle levels).
    task automatic do_xfer(input logic [7:0] b, input bit dcf, input bit m80, input bit junk);
        logic [13:0] exp_v, act_v, bad_a, bad_e;
        bit ok = 1'b1;
        string tag;
        in_valid   = 1'b1;
        in_data    = b;
        in_is_data = dcf;
        mode_80    = m80;
        @(posedge clk);
        @(negedge clk);
        for (int idx = 0; idx <= TOTAL; idx++) begin
            if (idx == 0) begin
                if (junk) begin
                    in_data    = ~b;
                    in_is_data = ~dcf;
                    mode_80    = ~m80;
                end else begin
                    in_valid = 1'b0;
                end
            end
            if (idx == TOTAL - 1) in_valid = 1'b0;
            exp_v = expect_pins(idx, m80, b, dcf);
            act_v = pins_now();
            if (ok && act_v !== exp_v) begin
                ok = 1'b0;
                bad_a = act_v;
                bad_e = exp_v;
            end
            if (idx < TOTAL) @(negedge clk);
        end
        tag = junk ? "R2 R3 R6 R7 R8 R10" : (m80 ? "R5 R3 R6 R7 R8 R10" : "R4 R3 R6 R7 R8 R10");
        check(ok, tag, {18'd0, bad_a}, {18'd0, bad_e});
    endtask

    initial begin
        int seed_v;
        seed_v = $urandom(32'h5EED_0042);
        repeat (3) @(negedge clk);
        // R1: levels while reset is held
        check(pins_now() === expect_pins(TOTAL, 1'b0, 8'h00, 1'b0), "R1",
              {18'd0, pins_now()}, {18'd0, expect_pins(TOTAL, 1'b0, 8'h00, 1'b0)});
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        // R1: levels after reset release, no request
        check(pins_now() === expect_pins(TOTAL, 1'b0, 8'h00, 1'b0), "R1",
              {18'd0, pins_now()}, {18'd0, expect_pins(TOTAL, 1'b0, 8'h00, 1'b0)});

        // directed corners
        do_xfer(8'hAE, 1'b0, 1'b0, 1'b0);   // R4 command, enable-style
        do_xfer(8'h5A, 1'b1, 1'b0, 1'b0);   // R4 data, enable-style
        do_xfer(8'h81, 1'b0, 1'b1, 1'b0);   // R5 command, strobe-style
        do_xfer(8'hFF, 1'b1, 1'b1, 1'b0);   // R5 all ones
        do_xfer(8'h00, 1'b1, 1'b0, 1'b0);   // R10 back to enable-style idle
        do_xfer(8'h3C, 1'b0, 1'b1, 1'b1);   // R2 busy-time input changes ignored
        do_xfer(8'hC3, 1'b1, 1'b0, 1'b1);   // R2 same, enable-style

        // constrained random
        for (int k = 0; k < 40; k++) begin
            do_xfer(8'($urandom), 1'($urandom), 1'($urandom), (($urandom % 4) == 0));
        end

        // R9: requests held back to back give the minimum spacing
        check(min_gap == TOTAL + 1, "R9", 32'(min_gap), 32'(TOTAL + 1));

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end

endmodule